// File: doc/BRIEF.md
# System Control Register with Keyboard-Driven Power Sequencing

This block holds the 16-bit system control and status word of a small microcontroller, together with the event and power logic that sits beside it. The CPU writes the word to set the direction of a 16-pin bidirectional port in four groups, to store a five-bit memory configuration, and to stop, slow or power down its own clock. A sticky status bit records any low level on port pin 1, and that pin also raises a maskable event interrupt.

A second part watches the keyboard input lines. A low on the pair KB0/KB1 puts the system into a power-off state. A low on either wake pair (KB9/KB10 or KB0/KB10) is then held as a hold phase. Releasing that pair issues a one-cycle reset and returns the block to running. While running, a fresh low on a wake pair requests a HALT interrupt. A rising edge on any keyboard line gives a wake pulse that brings the CPU out of idle. Every pin input passes through a synchronizer before it is used.

Top module: `sysctl_top`

## Requirements
- R1: After reset, rd_data reads 0x0C00, pp_dir_in reads 0x0001, clk_run is 1 and clk_div8, pwr_down, off_state, sys_rst, halt_req, evt_req and wake are 0.
- R2: Word bit 0 makes pins 3..1 inputs when 1, bit 1 pins 7..4, bit 2 pins 11..8 and bit 3 pins 15..12 (pp_dir_in bit n = 1 means pin n is an input). Pin 0 is always an input. The change is seen one cycle after the write.
- R3: Word bit 4 is set three cycles after pp1_pin goes low, whether that pin is an input or an output. It stays set until any write, and the value written to bit 4 is ignored. A set in the same cycle as a write wins.
- R4: Word bits 9..5 are plain read/write storage and also drive mem_cfg. Bits 15..13 always read 0.
- R5: clk_run follows word bit 10, clk_div8 is the inverse of bit 11, and pwr_down follows bit 12.
- R6: While running, KB0 and KB1 both low sets off_state three cycles later.
- R7: While off, a low on KB9/KB10 or KB0/KB10 keeps off_state at 1. Releasing the pair makes sys_rst 1 for exactly one cycle, and off_state falls in that same cycle.
- R8: While running, a new low on either wake pair makes halt_req 1 for exactly one cycle, three cycles after the pin change. halt_vec is always 0x78.
- R9: evt_req is 1 while the synchronized pp1_pin is low and psw_prio is 0. It follows psw_prio after one cycle. evt_vec is always 0x40.
- R10: A 0-to-1 change on any kb_pins line gives wake = 1 for one cycle, three cycles after the change. A 1-to-0 change gives no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Current control and status word |
| pp1_pin | input | 1 | Level of port pin 1, asynchronous |
| kb_pins | input | KB_W | Keyboard lines KB0..KB10, asynchronous, idle high |
| psw_prio | input | 1 | Interrupt priority bit of the PSW (1 masks the event interrupt) |
| pp_dir_in | output | 16 | Per-pin direction, 1 = input |
| mem_cfg | output | 5 | Memory configuration field |
| clk_run | output | 1 | CPU clock enable |
| clk_div8 | output | 1 | Divide the CPU clock by 8 |
| pwr_down | output | 1 | CPU power-down request |
| off_state | output | 1 | Power-off state (includes the hold phase) |
| sys_rst | output | 1 | One-cycle reset pulse when leaving power-off |
| halt_req | output | 1 | One-cycle HALT interrupt request |
| halt_vec | output | 8 | HALT vector address, 0x78 |
| evt_req | output | 1 | Event interrupt request |
| evt_vec | output | 8 | Event vector address, 0x40 |
| wake | output | 1 | One-cycle wake-from-idle pulse |

## Verification
A write changes the word and its outputs one cycle after the write strobe is taken. Anything that starts at a pin (the sticky bit, the power states, sys_rst, halt_req, evt_req and wake) shows up three cycles after the pin changes: two synchronizer stages, then one output register. A change on psw_prio alone shows up on evt_req after one cycle. The driver records each expected value together with the cycle in which it is due. The monitor compares it on the falling edge of exactly that cycle. For every pulse it also checks that the value has returned to zero one cycle later.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int CSR_W      = 16;
   localparam int DIR_GROUPS = 4;
   localparam int EVT_BIT    = 4;
   localparam int MEM_LO     = 5;
   localparam int MEM_HI     = 9;
   localparam int RUN_BIT    = 10;
   localparam int FULL_BIT   = 11;
   localparam int PDN_BIT    = 12;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_OFF  = 2'd1,
      PS_HOLD = 2'd2
   } pwr_state_t;

endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
   parameter int               W      = 1,
   parameter int               STAGES = 2,
   parameter logic [W-1:0]     RST_V  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   initial begin
      if (STAGES < 2) $error("sysctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
      end else begin
         stg[0] <= d_async;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/sysctl_csr.sv
module sysctl_csr
   import sysctl_pkg::*;
#(
   parameter int PORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CSR_W-1:0]  wr_data,
   input  logic              pin_low_s,
   output logic [CSR_W-1:0]  csr_q,
   output logic [PORT_W-1:0] dir_in
);

   localparam int GRP_PINS = PORT_W / DIR_GROUPS;
   localparam int CTL_W    = PDN_BIT - MEM_LO + 1;

   initial begin
      if (PORT_W % DIR_GROUPS != 0) $error("sysctl_csr: PORT_W must split into groups");
   end

   logic [DIR_GROUPS-1:0] dir_q;
   logic [CTL_W-1:0]      ctl_q;
   logic                  evt_q;
   logic                  unused_wr;

   assign unused_wr = ^{wr_data[CSR_W-1:PDN_BIT+1], wr_data[EVT_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         ctl_q <= CTL_W'((1 << (RUN_BIT - MEM_LO)) | (1 << (FULL_BIT - MEM_LO)));
         evt_q <= 1'b0;
      end else begin
         if (wr_en) begin
            dir_q <= wr_data[DIR_GROUPS-1:0];
            ctl_q <= wr_data[PDN_BIT:MEM_LO];
         end
         // a fresh low on the pin wins over the clearing write
         evt_q <= pin_low_s | (evt_q & ~wr_en);
      end
   end

   always_comb begin
      csr_q                    = '0;
      csr_q[DIR_GROUPS-1:0]    = dir_q;
      csr_q[EVT_BIT]           = evt_q;
      csr_q[PDN_BIT:MEM_LO]    = ctl_q;
   end

   genvar p;
   generate
      for (p = 0; p < PORT_W; p++) begin : g_dir
         if (p == 0) begin : g_fixed
            assign dir_in[p] = 1'b1;
         end else begin : g_grp
            assign dir_in[p] = dir_q[p / GRP_PINS];
         end
      end
   endgenerate

endmodule

// File: rtl/sysctl_pwrseq.sv
module sysctl_pwrseq
   import sysctl_pkg::*;
#(
   parameter int KB_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [KB_W-1:0] kb_s,
   input  logic            pin_low_s,
   input  logic            psw_prio,
   output logic            off_state,
   output logic            sys_rst,
   output logic            halt_req,
   output logic            evt_req,
   output logic            wake
);

   initial begin
      if (KB_W < 11) $error("sysctl_pwrseq: KB_W must cover lines 0..10");
   end

   pwr_state_t      st_q;
   logic            hold_q;
   logic [KB_W-1:0] kb_q;
   logic            hold_now;
   logic            off_now;

   assign hold_now = (~kb_s[9] & ~kb_s[10]) | (~kb_s[0] & ~kb_s[10]);
   assign off_now  = ~kb_s[0] & ~kb_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_RUN;
         hold_q   <= 1'b0;
         kb_q     <= '1;
         sys_rst  <= 1'b0;
         halt_req <= 1'b0;
         evt_req  <= 1'b0;
         wake     <= 1'b0;
      end else begin
         hold_q   <= hold_now;
         kb_q     <= kb_s;
         sys_rst  <= 1'b0;
         halt_req <= 1'b0;
         evt_req  <= pin_low_s & ~psw_prio;
         wake     <= |(kb_s & ~kb_q);
         unique case (st_q)
            PS_RUN: begin
               if (off_now)                  st_q <= PS_OFF;
               else if (hold_now && !hold_q) halt_req <= 1'b1;
            end
            PS_OFF: begin
               if (hold_now) st_q <= PS_HOLD;
            end
            PS_HOLD: begin
               if (!hold_now) begin
                  st_q    <= PS_RUN;
                  sys_rst <= 1'b1;
               end
            end
            default: st_q <= PS_RUN;
         endcase
      end
   end

   assign off_state = (st_q != PS_RUN);

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
   import sysctl_pkg::*;
#(
   parameter int          KB_W     = 11,
   parameter int          SYNC_N   = 2,
   parameter logic [7:0]  HALT_VA  = 8'h78,
   parameter logic [7:0]  EVT_VA   = 8'h40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [15:0]     wr_data,
   output logic [15:0]     rd_data,
   input  logic            pp1_pin,
   input  logic [KB_W-1:0] kb_pins,
   input  logic            psw_prio,
   output logic [15:0]     pp_dir_in,
   output logic [4:0]      mem_cfg,
   output logic            clk_run,
   output logic            clk_div8,
   output logic            pwr_down,
   output logic            off_state,
   output logic            sys_rst,
   output logic            halt_req,
   output logic [7:0]      halt_vec,
   output logic            evt_req,
   output logic [7:0]      evt_vec,
   output logic            wake
);

   localparam int SYN_W = KB_W + 1;

   logic [SYN_W-1:0] syn_q;
   logic [KB_W-1:0]  kb_s;
   logic             pin_low_s;

   sysctl_sync #(.W(SYN_W), .STAGES(SYNC_N), .RST_V('1)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({pp1_pin, kb_pins}),
      .q_sync  (syn_q)
   );

   assign kb_s      = syn_q[KB_W-1:0];
   assign pin_low_s = ~syn_q[KB_W];

   sysctl_csr #(.PORT_W(16)) i_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .pin_low_s (pin_low_s),
      .csr_q     (rd_data),
      .dir_in    (pp_dir_in)
   );

   sysctl_pwrseq #(.KB_W(KB_W)) i_pwr (
      .clk       (clk),
      .rst_n     (rst_n),
      .kb_s      (kb_s),
      .pin_low_s (pin_low_s),
      .psw_prio  (psw_prio),
      .off_state (off_state),
      .sys_rst   (sys_rst),
      .halt_req  (halt_req),
      .evt_req   (evt_req),
      .wake      (wake)
   );

   assign mem_cfg  = rd_data[MEM_HI:MEM_LO];
   assign clk_run  = rd_data[RUN_BIT];
   assign clk_div8 = ~rd_data[FULL_BIT];
   assign pwr_down = rd_data[PDN_BIT];
   assign halt_vec = HALT_VA;
   assign evt_vec  = EVT_VA;

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic [15:0] rd_data,
   input logic [15:0] pp_dir_in,
   input logic        psw_prio,
   input logic        off_state,
   input logic        sys_rst,
   input logic        halt_req,
   input logic        evt_req,
   input logic        wake
);

   AST_DIR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pp_dir_in[3:1] == {3{$past(wr_data[0])}}); // R2

   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[4] && !wr_en) |=> rd_data[4]); // R3

   AST_CTL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[12:5] == $past(wr_data[12:5])); // R4

   AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[15:13] == 3'b000); // R4

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> !sys_rst); // R7

   AST_RST_LEAVES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> (!off_state && $past(off_state))); // R7

   AST_HALT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> (!off_state && $past(!off_state))); // R8

   AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> !halt_req); // R8

   AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_req |-> $past(!psw_prio)); // R9

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake); // R10

endmodule

bind sysctl_top sysctl_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .pp_dir_in (pp_dir_in),
   .psw_prio  (psw_prio),
   .off_state (off_state),
   .sys_rst   (sys_rst),
   .halt_req  (halt_req),
   .evt_req   (evt_req),
   .wake      (wake)
);

// File: tb/test_sysctl_top.sv
`timescale 1ns/1ps
module test_sysctl_top;

   localparam int KB_W = 11;
   localparam int S_RD = 0, S_DIR = 1, S_MEM = 2, S_RUN = 3, S_DIV = 4, S_PDN = 5,
                  S_OFF = 6, S_RST = 7, S_HALT = 8, S_HVEC = 9, S_EVT = 10,
                  S_EVEC = 11, S_WAKE = 12;

   typedef struct {
      int          due;
      int          sig;
      logic [15:0] exp;
      string       req;
   } item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [15:0]     wr_data = '0;
   logic            pp1_pin = 1'b1;
   logic [KB_W-1:0] kb_pins = '1;
   logic            psw_prio = 1'b1;
   logic [15:0]     rd_data, pp_dir_in;
   logic [4:0]      mem_cfg;
   logic            clk_run, clk_div8, pwr_down, off_state, sys_rst;
   logic            halt_req, evt_req, wake;
   logic [7:0]      halt_vec, evt_vec;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   item_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sysctl_top #(.KB_W(KB_W)) i_sysctl_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .pp1_pin(pp1_pin), .kb_pins(kb_pins), .psw_prio(psw_prio), .pp_dir_in(pp_dir_in),
      .mem_cfg(mem_cfg), .clk_run(clk_run), .clk_div8(clk_div8), .pwr_down(pwr_down),
      .off_state(off_state), .sys_rst(sys_rst), .halt_req(halt_req), .halt_vec(halt_vec),
      .evt_req(evt_req), .evt_vec(evt_vec), .wake(wake)
   );

   function automatic logic [15:0] observe(int sig);
      case (sig)
         S_RD:    return rd_data;
         S_DIR:   return pp_dir_in;
         S_MEM:   return {11'd0, mem_cfg};
         S_RUN:   return {15'd0, clk_run};
         S_DIV:   return {15'd0, clk_div8};
         S_PDN:   return {15'd0, pwr_down};
         S_OFF:   return {15'd0, off_state};
         S_RST:   return {15'd0, sys_rst};
         S_HALT:  return {15'd0, halt_req};
         S_HVEC:  return {8'd0, halt_vec};
         S_EVT:   return {15'd0, evt_req};
         S_EVEC:  return {8'd0, evt_vec};
         default: return {15'd0, wake};
      endcase
   endfunction

   // monitor: compare every item in the cycle it is due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         logic [15:0] act;
         it  = sb.pop_front();
         act = observe(it.sig);
         n_chk++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s sig %0d cycle %0d: actual 0x%04h expected 0x%04h",
                     it.req, it.sig, cyc, act, it.exp);
         end
      end
   end

   task automatic expect_in(int dly, int sig, logic [15:0] exp, string req);
      item_t it;
      it.due = cyc + dly;
      it.sig = sig;
      it.exp = exp;
      it.req = req;
      sb.push_back(it);
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_write(logic [15:0] d);
      step();
      wr_en   = 1'b1;
      wr_data = d;
      step();
      wr_en   = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_in(1, S_RD,   16'h0C00, "R1");
      expect_in(1, S_DIR,  16'h0001, "R1");
      expect_in(1, S_RUN,  16'h1,    "R1");
      expect_in(1, S_DIV,  16'h0,    "R1");
      expect_in(1, S_PDN,  16'h0,    "R1");
      expect_in(1, S_OFF,  16'h0,    "R1");
      expect_in(1, S_EVT,  16'h0,    "R1");
      expect_in(1, S_HVEC, 16'h0078, "R8");
      expect_in(1, S_EVEC, 16'h0040, "R9");
      idle(4);

      // R2 R4 R5 mixed write
      do_write(16'h12A5);
      expect_in(0, S_RD,  16'h12A5, "R4");
      expect_in(0, S_DIR, 16'h0F0F, "R2");
      expect_in(0, S_MEM, 16'h0015, "R4");
      expect_in(0, S_RUN, 16'h0,    "R5");
      expect_in(0, S_DIV, 16'h1,    "R5");
      expect_in(0, S_PDN, 16'h1,    "R5");
      idle(3);
      do_write(16'hFFFF);
      expect_in(0, S_RD,  16'h1FEF, "R4");
      expect_in(0, S_DIR, 16'hFFFF, "R2");
      idle(3);
      do_write(16'h0C02);
      expect_in(0, S_DIR, 16'h00F1, "R2");
      expect_in(0, S_RUN, 16'h1,    "R5");
      expect_in(0, S_DIV, 16'h0,    "R5");
      idle(3);
      do_write(16'h0C00);
      idle(3);

      // R3 R9 pin 1 low, event masked first
      step();
      pp1_pin = 1'b0;
      expect_in(2, S_RD,  16'h0C00, "R3");
      expect_in(3, S_RD,  16'h0C10, "R3");
      expect_in(3, S_EVT, 16'h0,    "R9");
      idle(5);
      psw_prio = 1'b0;
      expect_in(1, S_EVT, 16'h1, "R9");
      idle(4);
      do_write(16'h0C00);
      expect_in(0, S_RD, 16'h0C10, "R3");
      idle(2);
      pp1_pin = 1'b1;
      expect_in(3, S_EVT, 16'h0,    "R9");
      expect_in(3, S_RD,  16'h0C10, "R3");
      idle(6);
      do_write(16'h0C10);
      expect_in(0, S_RD, 16'h0C00, "R3");
      idle(3);
      psw_prio = 1'b1;

      // R10 wake on rising line only
      kb_pins[5] = 1'b0;
      expect_in(3, S_WAKE, 16'h0, "R10");
      expect_in(4, S_WAKE, 16'h0, "R10");
      idle(6);
      kb_pins[5] = 1'b1;
      expect_in(3, S_WAKE, 16'h1, "R10");
      expect_in(4, S_WAKE, 16'h0, "R10");
      idle(6);

      // R8 halt while running
      kb_pins[9] = 1'b0;
      kb_pins[10] = 1'b0;
      expect_in(3, S_HALT, 16'h1, "R8");
      expect_in(4, S_HALT, 16'h0, "R8");
      expect_in(4, S_OFF,  16'h0, "R8");
      idle(6);
      kb_pins[9] = 1'b1;
      kb_pins[10] = 1'b1;
      idle(6);

      // R6 enter power-off
      kb_pins[0] = 1'b0;
      kb_pins[1] = 1'b0;
      expect_in(2, S_OFF, 16'h0, "R6");
      expect_in(3, S_OFF, 16'h1, "R6");
      idle(6);
      kb_pins[0] = 1'b1;
      kb_pins[1] = 1'b1;
      expect_in(4, S_OFF, 16'h1, "R6");
      idle(6);

      // R7 hold then release
      kb_pins[0] = 1'b0;
      kb_pins[10] = 1'b0;
      expect_in(4, S_OFF,  16'h1, "R7");
      expect_in(4, S_RST,  16'h0, "R7");
      expect_in(4, S_HALT, 16'h0, "R7");
      idle(8);
      kb_pins[0] = 1'b1;
      kb_pins[10] = 1'b1;
      expect_in(2, S_OFF, 16'h1, "R7");
      expect_in(3, S_RST, 16'h1, "R7");
      expect_in(3, S_OFF, 16'h0, "R7");
      expect_in(4, S_RST, 16'h0, "R7");
      idle(6);

      // R8 new low after the reset
      kb_pins[9] = 1'b0;
      kb_pins[10] = 1'b0;
      expect_in(3, S_HALT, 16'h1, "R8");
      expect_in(4, S_HALT, 16'h0, "R8");
      idle(6);
      kb_pins[9] = 1'b1;
      kb_pins[10] = 1'b1;
      idle(6);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule